// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the functional clock. An 8-bit divider code sets the length of each half period to code+1 functional cycles, so the serial clock runs at the functional rate divided by 2·(code+1). The all-ones code is reserved as a bypass: the serial clock then runs at the full functional rate. Each division is an exact integer ratio, so software that picks the nearest setting below a target rate gets exactly the rate it computed.

The shifter raises `run_i` for the length of a transaction. The block answers with the serial clock level, a leading-edge strobe in the cycle the clock leaves its idle level, and a trailing-edge strobe in the cycle it returns. The idle level follows the polarity input. The divider code and the polarity are captured only while the generator is idle, so a change made during a transaction takes effect at the next one.

Start and stop are glitch free. The first half period sits at the idle level for its full length. When `run_i` falls during an active half, that half completes before the clock returns to idle, so no pulse is ever shorter than a half period.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rst` is held, `sclk_o` is 0 and `busy_o`, `lead_stb_o` and `trail_stb_o` are 0, whatever the polarity input.
- R2: While the generator is idle, `sclk_o` equals `cpol_i`, with a lag of at most two cycles after `cpol_i` changes.
- R3: For a code d in 0..254, counting m=0 as the first cycle after the edge that samples `run_i` high, `sclk_o` is at the idle level when floor(m/(d+1)) is even and at the active level when it is odd. Each half lasts d+1 cycles, the first half included.
- R4: In divided mode, `lead_stb_o` is high for exactly the cycles in which `sclk_o` moves from idle to active, and `trail_stb_o` for exactly the cycles in which it moves back.
- R5: With code 0xFF (all ones), starting one cycle after the start cycle, `sclk_o` is at the active level during the high phase of `clk` and at the idle level during the low phase. Both strobes are high in each cycle that carries such a pulse, and pulses continue through the cycle in which `run_i` is first sampled low.
- R6: If `run_i` is sampled low while `sclk_o` is in an idle half, `sclk_o` stays idle and `busy_o` is low from the next cycle, with no strobe.
- R7: If `run_i` is sampled low while `sclk_o` is in an active half, that half still lasts its full d+1 cycles. The clock then returns to idle with a trailing strobe, and `busy_o` is low in that same cycle.
- R8: Changes to `div_code_i` or `cpol_i` while `busy_o` is high do not alter the clock of the transaction in progress.
- R9: `busy_o` is high from the first cycle after the start cycle until the stop completes as described in R5, R6 and R7. No strobe fires while the generator stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Transaction active request from the shifter |
| div_code_i | input | DIV_W | Half-period code; all ones selects bypass |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock level |
| lead_stb_o | output | 1 | Leading-edge strobe for the shifter |
| trail_stb_o | output | 1 | Trailing-edge strobe for the shifter |
| busy_o | output | 1 | Generator running or finishing a stop |

## Verification
The bench goes after the extreme codes: code 0 must toggle every cycle, and code 0xFE must hold each half for 255 cycles. A counter that is off by one shifts every edge of the traced waveform. Stops are aimed at both kinds of half. A design that cuts an active half short leaves a runt pulse and an early trailing strobe, and one that waits out an idle half holds `busy_o` too long. Divider and polarity changes made mid-transaction would bend the running waveform if they were captured at the wrong time. The bypass code is sampled in both clock phases, so a bypass that toggles only at functional-clock edges shows up as half rate.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    localparam int unsigned DIV_W_DEF = 8;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    // Captured per-transaction clock mode
    typedef struct packed {
        logic cpol;
        logic bypass;
    } sclk_mode_t;

    // Edge strobes toward the shifter
    typedef struct packed {
        logic lead;
        logic trail;
    } edge_stb_t;

endpackage

// File: rtl/spi_sclk_halfcnt.sv
module spi_sclk_halfcnt #(
    parameter int unsigned DIV_W = spi_sclk_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] limit,
    output logic             wrap
);
    logic [DIV_W-1:0] cnt_q;

    // A half period ends once the count has reached the limit
    assign wrap = (cnt_q == limit) && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_sclk_fsm.sv
module spi_sclk_fsm
    import spi_sclk_pkg::*;
#(
    parameter int unsigned DIV_W = spi_sclk_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    input  logic             cpol,
    input  logic             wrap,
    input  logic             byp_tail,
    output logic             cnt_clr,
    output logic [DIV_W-1:0] limit,
    output sclk_mode_t       mode,
    output logic             phase,
    output edge_stb_t        stb,
    output logic             byp_act,
    output logic             running
);
    gen_state_e       state_q, state_d;
    logic             ph_q, ph_d;
    logic [DIV_W-1:0] div_q;
    logic             cpol_q;
    edge_stb_t        stb_q, stb_d;
    logic             is_byp;

    assign is_byp = (div_q == '1);

    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        stb_d   = '0;
        unique case (state_q)
            GEN_IDLE: begin
                ph_d = 1'b0;
                if (run) begin
                    state_d = GEN_RUN;
                end
            end
            GEN_RUN: begin
                if (is_byp) begin
                    if (!run) begin
                        state_d = GEN_IDLE;
                    end
                end else if (wrap) begin
                    if (ph_q) begin
                        ph_d        = 1'b0;
                        stb_d.trail = 1'b1;
                        if (!run) begin
                            state_d = GEN_IDLE;
                        end
                    end else if (run) begin
                        ph_d       = 1'b1;
                        stb_d.lead = 1'b1;
                    end else begin
                        state_d = GEN_IDLE;
                    end
                end else if (!ph_q && !run) begin
                    // Idle half: stopping here leaves no partial pulse
                    state_d = GEN_IDLE;
                end
            end
            default: state_d = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            ph_q    <= 1'b0;
            stb_q   <= '0;
            div_q   <= '0;
            cpol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            stb_q   <= stb_d;
            // Configuration is taken only between transactions
            if (state_q == GEN_IDLE) begin
                div_q <= div_code;
            end
            if (state_q == GEN_IDLE && !byp_tail) begin
                cpol_q <= cpol;
            end
        end
    end

    assign cnt_clr     = (state_q == GEN_IDLE);
    assign limit       = div_q;
    assign mode.cpol   = cpol_q;
    assign mode.bypass = is_byp;
    assign phase       = ph_q;
    assign stb         = stb_q;
    assign byp_act     = (state_q == GEN_RUN) && is_byp;
    assign running     = (state_q == GEN_RUN);
endmodule

// File: rtl/spi_sclk_bypass.sv
module spi_sclk_bypass (
    input  logic clk,
    input  logic rst,
    input  logic byp_act,
    output logic gate,
    output logic tail
);
    // Enable for the full-rate path, moved only while clk is low
    always_ff @(negedge clk) begin
        if (rst) begin
            gate <= 1'b0;
        end else begin
            gate <= byp_act;
        end
    end

    // Posedge copy that lines up with the cycles carrying a pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            tail <= 1'b0;
        end else begin
            tail <= byp_act;
        end
    end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int unsigned DIV_W = spi_sclk_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_code_i,
    input  logic             cpol_i,
    output logic             sclk_o,
    output logic             lead_stb_o,
    output logic             trail_stb_o,
    output logic             busy_o
);
    logic             cnt_clr;
    logic             wrap;
    logic [DIV_W-1:0] limit;
    sclk_mode_t       mode;
    logic             phase;
    edge_stb_t        stb;
    logic             byp_act;
    logic             running;
    logic             gate;
    logic             tail;

    spi_sclk_halfcnt #(.DIV_W(DIV_W)) u_halfcnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .limit (limit),
        .wrap  (wrap)
    );

    spi_sclk_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run      (run_i),
        .div_code (div_code_i),
        .cpol     (cpol_i),
        .wrap     (wrap),
        .byp_tail (tail),
        .cnt_clr  (cnt_clr),
        .limit    (limit),
        .mode     (mode),
        .phase    (phase),
        .stb      (stb),
        .byp_act  (byp_act),
        .running  (running)
    );

    spi_sclk_bypass u_bypass (
        .clk     (clk),
        .rst     (rst),
        .byp_act (byp_act),
        .gate    (gate),
        .tail    (tail)
    );

    assign sclk_o      = mode.cpol ^ (phase | (gate & clk));
    assign lead_stb_o  = stb.lead  | tail;
    assign trail_stb_o = stb.trail | tail;
    assign busy_o      = running   | tail;
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             run_i,
    input logic [DIV_W-1:0] div_code_i,
    input logic             cpol_i,
    input logic             sclk_o,
    input logic             lead_stb_o,
    input logic             trail_stb_o,
    input logic             busy_o
);
    logic [DIV_W-1:0] ck_div;
    logic [DIV_W:0]   len;
    logic             sclk_prev;

    // Shadow code and half-length counter for the window check
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_div    <= '0;
            len       <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_o;
            if (!busy_o) begin
                ck_div <= div_code_i;
                len    <= '0;
            end else if (sclk_o != sclk_prev) begin
                len <= {{DIV_W{1'b0}}, 1'b1};
            end else begin
                len <= len + 1'b1;
            end
        end
    end

    AST_HALF_LEN: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_o) && (sclk_o != $past(sclk_o)) && (ck_div != '1))
        |-> (len == ({1'b0, ck_div} + 1'b1))); // R3

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o) && !$past(rst) && (cpol_i == $past(cpol_i)))
        |-> (sclk_o == cpol_i)); // R2

    AST_LEAD_MOVES: assert property (@(posedge clk) disable iff (rst)
        (lead_stb_o && !trail_stb_o) |-> (sclk_o != $past(sclk_o))); // R4

    AST_TRAIL_MOVES: assert property (@(posedge clk) disable iff (rst)
        (trail_stb_o && !lead_stb_o) |-> (sclk_o != $past(sclk_o))); // R4

    AST_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_o) && (sclk_o != $past(sclk_o)))
        |-> (lead_stb_o || trail_stb_o)); // R4

    AST_QUIET_STROBES: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> !(lead_stb_o || trail_stb_o)); // R9
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .div_code_i  (div_code_i),
    .cpol_i      (cpol_i),
    .sclk_o      (sclk_o),
    .lead_stb_o  (lead_stb_o),
    .trail_stb_o (trail_stb_o),
    .busy_o      (busy_o)
);

// File: tb/spi_sclk_gen_bench.sv
module spi_sclk_gen_bench;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run_i = 1'b0;
    logic [DIV_W-1:0] div_code_i = '0;
    logic             cpol_i = 1'b0;
    logic             sclk_o;
    logic             lead_stb_o;
    logic             trail_stb_o;
    logic             busy_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spi_sclk_gen #(.DIV_W(DIV_W)) u_spi_sclk_gen (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run_i),
        .div_code_i  (div_code_i),
        .cpol_i      (cpol_i),
        .sclk_o      (sclk_o),
        .lead_stb_o  (lead_stb_o),
        .trail_stb_o (trail_stb_o),
        .busy_o      (busy_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    // Expected divided-mode outputs at cycle m for half length h, stop index d
    function automatic void exp_div(input int m, input int h, input int d,
                                    output logic lvl, output logic lead,
                                    output logic trail, output logic busy);
        int b;
        if (m < d) begin
            lvl   = ((m / h) % 2) == 1;
            busy  = 1'b1;
            lead  = (m > 0) && (m % h == 0) && lvl;
            trail = (m > 0) && (m % h == 0) && !lvl;
        end else if ((((d - 1) / h) % 2) == 1) begin
            b     = ((d - 1) / h + 1) * h;
            lvl   = (m < b);
            busy  = (m < b);
            lead  = 1'b0;
            trail = (m == b);
        end else begin
            lvl   = 1'b0;
            busy  = 1'b0;
            lead  = 1'b0;
            trail = 1'b0;
        end
    endfunction

    function automatic int stop_end(input int h, input int d);
        if ((((d - 1) / h) % 2) == 1) return ((d - 1) / h + 1) * h;
        return d;
    endfunction

    task automatic run_div(input string req, input int div, input logic pol,
                           input int d, input logic alter);
        int h = div + 1;
        int last = stop_end(div + 1, d);
        logic lvl, lead, trail, busy;
        div_code_i = div[DIV_W-1:0];
        cpol_i     = pol;
        repeat (3) @(posedge clk);
        #1 run_i = 1'b1;
        for (int m = 0; m <= last; m++) begin
            @(posedge clk);
            #2;
            exp_div(m, h, d, lvl, lead, trail, busy);
            check(req,  "sclk",  {31'd0, sclk_o},      {31'd0, pol ^ lvl});
            check("R4", "lead",  {31'd0, lead_stb_o},  {31'd0, lead});
            check("R4", "trail", {31'd0, trail_stb_o}, {31'd0, trail});
            check("R9", "busy",  {31'd0, busy_o},      {31'd0, busy});
            if (alter && m == 1) begin
                div_code_i = DIV_W'(div + 3);
                cpol_i     = ~pol;
            end
            if (m == d - 1) run_i = 1'b0;
        end
        div_code_i = div[DIV_W-1:0];
        cpol_i     = pol;
    endtask

    task automatic run_byp(input logic pol, input int d);
        logic pulse;
        div_code_i = '1;
        cpol_i     = pol;
        repeat (3) @(posedge clk);
        #1 run_i = 1'b1;
        for (int m = 0; m <= d + 2; m++) begin
            @(posedge clk);
            #2;
            pulse = (m >= 1) && (m <= d);
            check("R5", "sclk high phase", {31'd0, sclk_o}, {31'd0, pol ^ pulse});
            check("R5", "lead",  {31'd0, lead_stb_o},  {31'd0, pulse});
            check("R5", "trail", {31'd0, trail_stb_o}, {31'd0, pulse});
            check("R9", "busy",  {31'd0, busy_o},      {31'd0, (m <= d)});
            #4;
            check("R5", "sclk low phase", {31'd0, sclk_o}, {31'd0, pol});
            if (m == d - 1) run_i = 1'b0;
        end
    endtask

    task automatic check_idle(input logic pol);
        cpol_i = pol;
        repeat (3) @(posedge clk);
        #2;
        check("R2", "idle sclk",    {31'd0, sclk_o}, {31'd0, pol});
        check("R9", "idle busy",    {31'd0, busy_o}, 32'd0);
        check("R9", "idle strobes", {30'd0, lead_stb_o, trail_stb_o}, 32'd0);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20251);
        cpol_i = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        check("R1", "reset sclk",    {31'd0, sclk_o}, 32'd0);
        check("R1", "reset busy",    {31'd0, busy_o}, 32'd0);
        check("R1", "reset strobes", {30'd0, lead_stb_o, trail_stb_o}, 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;

        check_idle(1'b1);
        check_idle(1'b0);

        run_div("R3", 0, 1'b0, 9, 1'b0);
        run_div("R3", 254, 1'b1, 300, 1'b0);
        run_div("R6", 3, 1'b0, 10, 1'b0);
        run_div("R7", 3, 1'b1, 6, 1'b0);
        run_div("R8", 2, 1'b0, 14, 1'b1);
        check_idle(1'b0);
        run_byp(1'b0, 5);
        run_byp(1'b1, 3);
        check_idle(1'b1);

        for (int i = 0; i < 16; i++) begin
            int   dv;
            int   stp;
            logic pl;
            dv  = $urandom_range(0, 6);
            pl  = 1'($urandom_range(0, 1));
            stp = $urandom_range(1, 6 * (dv + 1));
            run_div("R3", dv, pl, stp, 1'($urandom_range(0, 1)));
            check_idle(pl);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule